// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

This block turns internal burst read requests into read cycles on an external asynchronous memory that supports page mode. A request gives a byte start address and a beat count. The block drives the memory address bus, one active-low chip select and one active-low read strobe, and it samples the memory data bus at the end of each beat. Read data goes back to the requester one beat at a time, each beat marked by a single-cycle valid flag, and a done flag marks the last beat.

In page mode the memory answers the first read of a page slowly and later reads in the same page quickly. The block therefore keeps track of the page the previous beat used. It applies a long programmable pulse to the first beat of a burst and to any beat that enters a new page, and a short programmable pulse to the other beats. Both strobes stay low for the whole burst. Page size, bus width, page-mode enable and the two pulse lengths come from configuration inputs, which the block samples when it accepts a request.

Top module: `apm_read_seq`

## Requirements
- R1: While reset is held and just after it, `mem_cs_n` and `mem_rd_n` are high, `req_ready` is high, and `rd_valid` and `rd_done` are low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Both strobes go low in the next cycle, `req_ready` stays low until the burst ends, and all `cfg_*` inputs are taken at acceptance, so later changes to them have no effect on that burst.
- R3: `cfg_page_sel` values 0, 1, 2 and 3 select pages of 4, 8, 16 and 32 bytes. Each page is aligned to its own size, so address bits [25:2+sel] name the page and bits [1+sel:0] the offset inside it. Beat addresses rise by the bus width in bytes.
- R4: The first beat of every burst holds the strobes low for `cfg_first_pulse` cycles.
- R5: With `cfg_page_en`=1, a beat whose page matches the previous beat's page holds the strobes low for `cfg_inpage_pulse` cycles, and the strobes do not rise between beats.
- R6: With `cfg_page_en`=1, the first beat after a burst crosses a page boundary uses `cfg_first_pulse` and the strobes stay low through the crossing.
- R7: With `cfg_page_en`=0, every beat uses `cfg_first_pulse`, and the strobes go high for exactly one cycle between beats.
- R8: `cfg_width_sel` 0 selects an 8-bit memory (step 1 byte), 1 selects a 16-bit memory (address bit 0 forced to 0, step 2 bytes), and 2 or 3 select a 32-bit memory (address bits [1:0] forced to 0, step 4 bytes).
- R9: `mem_data` is captured on the last clock of each pulse. It appears on `rd_data` with `rd_valid` high for one cycle in the cycle after that clock, and `mem_addr` is constant during a pulse.
- R10: In the cycle where the last beat's `rd_valid` is high, `rd_done` is high, both strobes are high and `req_ready` is high.
- R11: A pulse length of 0 behaves as a length of 1.
- R12: `mem_cs_n` and `mem_rd_n` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W (26) | Byte start address |
| req_last_idx | input | LEN_W (5) | Number of beats minus one |
| cfg_page_en | input | 1 | Page mode enable |
| cfg_page_sel | input | 2 | Page size code: 4/8/16/32 bytes |
| cfg_width_sel | input | 2 | Memory data width code: 8/16/32 bits |
| cfg_first_pulse | input | PULSE_W (6) | Strobe cycles for a first access in a page |
| cfg_inpage_pulse | input | PULSE_W (6) | Strobe cycles for a later access in a page |
| mem_addr | output | ADDR_W (26) | Memory byte address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_data | input | DATA_W (32) | Memory read data |
| rd_data | output | DATA_W (32) | Captured beat data |
| rd_valid | output | 1 | One-cycle flag for `rd_data` |
| rd_done | output | 1 | Flag for the last beat of the burst |

## Verification
Directed bursts cover the cases that separate the two pulse lengths. A burst that starts near the end of a 32-byte page shows whether a boundary crossing brings back the long pulse while the strobes stay low. The same burst shape with page mode off has to show a one-cycle release between beats instead. A 16-bit burst from an odd address and an 8-bit burst across a 4-byte page check address alignment and step size. Zero pulse lengths check the clamp to one cycle. Random bursts vary page size, width, enable, pulse lengths, start address and beat count, and change the configuration inputs right after acceptance, which shows whether the block latched them.

// File: rtl/apm_pkg.sv
package apm_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } apm_state_e;

    // log2 of the memory word size in bytes for a width code
    function automatic logic [1:0] width_log2(input logic [1:0] width_sel);
        case (width_sel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // low two address bits kept after alignment to the word size
    function automatic logic [1:0] align_keep(input logic [1:0] width_sel);
        case (width_sel)
            2'd0:    return 2'b11;
            2'd1:    return 2'b10;
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/apm_page_tracker.sv
module apm_page_tracker #(
    parameter int ADDR_W = 26
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        width_sel,
    input  logic [1:0]        page_sel,
    input  logic              page_en,
    output logic [ADDR_W-1:0] next_addr,
    output logic              same_page
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_SIZES = 4;

    logic [ADDR_W-1:0]  step;
    logic [N_SIZES-1:0] match_by_size;

    assign step      = ADDR_W'(1) << apm_pkg::width_log2(width_sel);
    assign next_addr = cur_addr + step;

    // one page-number comparator per page size; size g covers 2^(g+2) bytes
    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        assign match_by_size[g] = (next_addr[ADDR_W-1:g+2] == cur_addr[ADDR_W-1:g+2]);
    end

    assign same_page = page_en && match_by_size[page_sel];
endmodule

// File: rtl/apm_pulse_pick.sv
module apm_pulse_pick #(
    parameter int PULSE_W = 6
) (
    input  logic [PULSE_W-1:0] first_len,
    input  logic [PULSE_W-1:0] short_len,
    input  logic               use_short,
    output logic [PULSE_W-1:0] len
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [PULSE_W-1:0] raw;

    assign raw = use_short ? short_len : first_len;
    // a zero length still takes one cycle
    assign len = (raw == '0) ? PULSE_W'(1) : raw;
endmodule

// File: rtl/apm_read_seq.sv
module apm_read_seq #(
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 5,
    parameter int PULSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_last_idx,
    input  logic               cfg_page_en,
    input  logic [1:0]         cfg_page_sel,
    input  logic [1:0]         cfg_width_sel,
    input  logic [PULSE_W-1:0] cfg_first_pulse,
    input  logic [PULSE_W-1:0] cfg_inpage_pulse,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_cs_n,
    output logic               mem_rd_n,
    input  logic [DATA_W-1:0]  mem_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               rd_done
);
    timeunit 1ns;
    timeprecision 1ps;

    import apm_pkg::*;

    typedef struct packed {
        apm_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   left;
        logic [PULSE_W-1:0] cnt;
        logic               page_en;
        logic [1:0]         page_sel;
        logic [1:0]         width_sel;
        logic [PULSE_W-1:0] first_len;
        logic [PULSE_W-1:0] short_len;
        logic               strobe_n;
        logic [DATA_W-1:0]  data;
        logic               valid;
        logic               done;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0]  next_addr;
    logic               same_page;
    logic [PULSE_W-1:0] start_len;
    logic [PULSE_W-1:0] beat_len;
    logic [ADDR_W-1:0]  aligned_req;

    // page compare for the beat after the current one
    apm_page_tracker #(.ADDR_W(ADDR_W)) u_track (
        .cur_addr  (r_q.addr),
        .width_sel (r_q.width_sel),
        .page_sel  (r_q.page_sel),
        .page_en   (r_q.page_en),
        .next_addr (next_addr),
        .same_page (same_page)
    );

    // first beat of a burst: always the long pulse, from live config
    apm_pulse_pick #(.PULSE_W(PULSE_W)) u_pick_start (
        .first_len (cfg_first_pulse),
        .short_len (cfg_inpage_pulse),
        .use_short (1'b0),
        .len       (start_len)
    );

    // following beats: latched config, short only inside the open page
    apm_pulse_pick #(.PULSE_W(PULSE_W)) u_pick_beat (
        .first_len (r_q.first_len),
        .short_len (r_q.short_len),
        .use_short (same_page),
        .len       (beat_len)
    );

    assign aligned_req = req_addr & {{(ADDR_W-2){1'b1}}, align_keep(cfg_width_sel)};

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.done  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st        = ST_PULSE;
                    r_d.addr      = aligned_req;
                    r_d.left      = req_last_idx;
                    r_d.cnt       = start_len;
                    r_d.page_en   = cfg_page_en;
                    r_d.page_sel  = cfg_page_sel;
                    r_d.width_sel = cfg_width_sel;
                    r_d.first_len = cfg_first_pulse;
                    r_d.short_len = cfg_inpage_pulse;
                    r_d.strobe_n  = 1'b0;
                end
            end
            ST_PULSE: begin
                if (r_q.cnt <= PULSE_W'(1)) begin
                    r_d.data  = mem_data;
                    r_d.valid = 1'b1;
                    if (r_q.left == '0) begin
                        r_d.st       = ST_IDLE;
                        r_d.strobe_n = 1'b1;
                        r_d.done     = 1'b1;
                    end else begin
                        r_d.left = r_q.left - LEN_W'(1);
                        r_d.addr = next_addr;
                        r_d.cnt  = beat_len;
                        if (r_q.page_en) begin
                            r_d.st = ST_PULSE;
                        end else begin
                            r_d.st       = ST_GAP;
                            r_d.strobe_n = 1'b1;
                        end
                    end
                end else begin
                    r_d.cnt = r_q.cnt - PULSE_W'(1);
                end
            end
            ST_GAP: begin
                r_d.st       = ST_PULSE;
                r_d.strobe_n = 1'b0;
            end
            default: begin
                r_d.st       = ST_IDLE;
                r_d.strobe_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.strobe_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_cs_n  = r_q.strobe_n;
    assign mem_rd_n  = r_q.strobe_n;
    assign rd_data   = r_q.data;
    assign rd_valid  = r_q.valid;
    assign rd_done   = r_q.done;
endmodule

// File: rtl/apm_read_seq_chk.sv
module apm_read_seq_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              rd_valid,
    input logic              rd_done
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_strobes_equal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n == mem_rd_n);

    assert_done_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (mem_cs_n && rd_valid && req_ready));

    assert_rise_after_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> rd_valid);

    assert_addr_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n) && !rd_valid) |-> $stable(mem_addr));

    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);

    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_cs_n && !req_ready));
endmodule

bind apm_read_seq apm_read_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .rd_valid  (rd_valid),
    .rd_done   (rd_done)
);

// File: tb/sim_apm_read_seq.sv
module sim_apm_read_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 26;
    localparam int DW = 32;
    localparam int LW = 5;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_last_idx = '0;
    logic          cfg_page_en = 1'b0;
    logic [1:0]    cfg_page_sel = '0;
    logic [1:0]    cfg_width_sel = '0;
    logic [PW-1:0] cfg_first_pulse = '0;
    logic [PW-1:0] cfg_inpage_pulse = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_rd_n;
    logic [DW-1:0] mem_data;
    logic [DW-1:0] rd_data;
    logic          rd_valid, rd_done;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    function automatic logic [DW-1:0] mem_model(input logic [AW-1:0] a);
        return {6'h2b, a} ^ {a[15:0], a[25:10]};
    endfunction

    assign mem_data = mem_model(mem_addr);

    apm_read_seq #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .PULSE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_last_idx(req_last_idx),
        .cfg_page_en(cfg_page_en), .cfg_page_sel(cfg_page_sel),
        .cfg_width_sel(cfg_width_sel), .cfg_first_pulse(cfg_first_pulse),
        .cfg_inpage_pulse(cfg_inpage_pulse),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_data(mem_data), .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s t=%0t actual=0x%0h expected=0x%0h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input logic [1:0] w);
        logic [AW-1:0] m;
        m = (w == 2'd0) ? '0 : (w == 2'd1) ? AW'(1) : AW'(3);
        return a & ~m;
    endfunction

    function automatic int step_of(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    task automatic run_req(input logic [AW-1:0] addr, input int last_idx, input bit pen,
                           input logic [1:0] psel, input logic [1:0] wsel,
                           input int pf, input int ps);
        logic [AW-1:0] a, na;
        int pfe, pse, p, pb;
        bit same;
        string ptag, atag;
        pfe  = (pf == 0) ? 1 : pf;
        pse  = (ps == 0) ? 1 : ps;
        pb   = 2 + psel;
        atag = (wsel == 2'd2) ? "R3" : "R8";
        a    = align(addr, wsel);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        req_valid        = 1'b1;
        req_addr         = addr;
        req_last_idx     = LW'(last_idx);
        cfg_page_en      = pen;
        cfg_page_sel     = psel;
        cfg_width_sel    = wsel;
        cfg_first_pulse  = PW'(pf);
        cfg_inpage_pulse = PW'(ps);
        @(posedge clk);
        #1;
        req_valid        = 1'b0;
        // scramble config: the burst must use the latched copy (R2)
        cfg_page_en      = $urandom_range(0, 1);
        cfg_page_sel     = 2'($urandom_range(0, 3));
        cfg_width_sel    = 2'($urandom_range(0, 3));
        cfg_first_pulse  = PW'($urandom_range(0, 9));
        cfg_inpage_pulse = PW'($urandom_range(0, 9));
        @(negedge clk);
        p    = pfe;
        ptag = (pf == 0) ? "R11 first pulse" : "R4 first pulse";
        for (int b = 0; b <= last_idx; b++) begin
            for (int k = 0; k < p; k++) begin
                if (k > 0) @(negedge clk);
                chk(mem_cs_n == 1'b0, ptag, mem_cs_n, 0);
                chk(mem_cs_n == mem_rd_n, "R12 strobes equal", mem_rd_n, mem_cs_n);
                chk(mem_addr == a, atag, mem_addr, a);
                chk(rd_done == 1'b0, "R10 no early done", rd_done, 0);
                if (k > 0) chk(rd_valid == 1'b0, "R9 valid inside pulse", rd_valid, 0);
            end
            @(negedge clk);
            chk(rd_valid == 1'b1, "R9 valid after pulse", rd_valid, 1);
            chk(rd_data == mem_model(a), "R9 data", rd_data, mem_model(a));
            if (b == last_idx) begin
                chk(rd_done == 1'b1 && mem_cs_n == 1'b1 && req_ready == 1'b1,
                    "R10 done and release", {rd_done, mem_cs_n, req_ready}, 3'b111);
            end else begin
                chk(rd_done == 1'b0, "R10 done only at end", rd_done, 0);
                na   = a + AW'(step_of(wsel));
                same = pen && ((na >> pb) == (a >> pb));
                if (!pen) begin
                    chk(mem_cs_n == 1'b1, "R7 release between beats", mem_cs_n, 1);
                    @(negedge clk);
                    p    = pfe;
                    ptag = "R7 long pulse per beat";
                end else if (same) begin
                    p    = pse;
                    ptag = (ps == 0) ? "R11 in-page pulse" : "R5 in-page pulse";
                end else begin
                    p    = pfe;
                    ptag = "R6 long pulse after crossing";
                end
                a = na;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(mem_cs_n == 1'b1 && mem_rd_n == 1'b1, "R1 strobes high in reset", {mem_cs_n, mem_rd_n}, 2'b11);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        chk(rd_valid == 1'b0 && rd_done == 1'b0, "R1 flags low in reset", {rd_valid, rd_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n == 1'b1 && req_ready == 1'b1, "R1 idle after reset", {mem_cs_n, req_ready}, 2'b11);

        // crossing inside a 32-byte page, 32-bit memory (R6)
        run_req(26'h18, 3, 1'b1, 2'd3, 2'd2, 5, 2);
        // zero lengths clamp to one cycle (R11)
        run_req(26'h40, 2, 1'b1, 2'd2, 2'd2, 0, 0);
        // page mode off: long pulse and a release per beat (R7)
        run_req(26'h18, 3, 1'b0, 2'd3, 2'd2, 3, 1);
        // 16-bit memory from an odd address, 8-byte page (R8)
        run_req(26'h101, 4, 1'b1, 2'd1, 2'd1, 4, 2);
        // 8-bit memory across a 4-byte page (R8, R3)
        run_req(26'h3, 2, 1'b1, 2'd0, 2'd0, 3, 1);
        // single beat with a long pulse (R4)
        run_req(26'h3ff_fffc, 0, 1'b1, 2'd0, 2'd2, 7, 1);

        for (int i = 0; i < 60; i++) begin
            run_req(AW'($urandom), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                    2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    $urandom_range(0, 5), $urandom_range(0, 3));
        end

        @(negedge clk);
        chk(mem_cs_n == 1'b1 && req_ready == 1'b1, "R10 idle at end", {mem_cs_n, req_ready}, 2'b11);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule